// File: doc/BRIEF.md
# ALU Status Flag Unit

This block keeps the status byte of an 8-bit accumulator machine. Each cycle the execution stage may present an operation class together with the two operands and the result it produced. When the flag-write strobe is high, the block derives new carry, digit-carry and zero flags from that operation. Subtract and compare report carry as the inverse of a borrow. The two rotate-through-carry classes load carry from the bit that leaves the accumulator. The current carry is visible on the status output, so the datapath can feed it into the vacated bit.

The same byte holds a power-down flag, a timeout flag and three page-select bits. Power-on reset, a watchdog-clear command, a sleep command and a watchdog timeout drive the two power flags. Software may rewrite the byte in one write cycle, but it cannot change the two power flags. All inputs are single-cycle strobes sampled on the rising clock edge. There is no stream handshake and no back-pressure: every write is accepted in the cycle it is presented.

Top module: `stat_flag_unit`

## Requirements
- R1: After reset (`rst_n` low) the status byte reads 0x18. The page bits [7:5] are 0, the timeout flag (bit 4) is 1, the power-down flag (bit 3) is 1, and zero (bit 2), digit carry (bit 1) and carry (bit 0) are all 0.
- R2: For op 0 (add) with the flag strobe high, carry becomes the carry out of the 8-bit sum of A and B. Digit carry becomes the carry out of the sum of their low nibbles.
- R3: For op 1 (subtract, A−B) and op 2 (compare), carry is 1 when A≥B and 0 when a borrow occurs. Digit carry follows the same rule on the low nibbles.
- R4: For op 3 (rotate left) carry takes A bit 7, and for op 4 (rotate right) carry takes A bit 0. Zero and digit carry are left unchanged.
- R5: For ops 0, 1, 2, 5 and 6, the zero flag becomes 1 when the presented result is 0x00 and becomes 0 otherwise.
- R6: Ops 5 (logic) and 6 (move) leave carry and digit carry unchanged. Op 7 changes no flag.
- R7: A watchdog-clear command sets the power-down flag. A sleep command without watchdog-clear clears it.
- R8: A watchdog timeout clears the timeout flag. A watchdog-clear command without timeout sets it.
- R9: A software write loads bits 7:5 and 2:0 from the write data. Bits 4:3 of the write data are ignored.
- R10: When the flag strobe and a software write coincide, each flag the operation updates takes the operation's value. All other writable bits take the write data.
- R11: With neither the flag strobe nor a software write, bits 7:5 and 2:0 hold their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| op_i | input | 3 | Operation class, encodings as in R2–R6 |
| opa_i | input | 8 | Operand A (accumulator side) |
| opb_i | input | 8 | Operand B |
| res_i | input | 8 | ALU result, used for the zero flag |
| flag_we_i | input | 1 | Apply flag update of op_i this cycle |
| wdt_clr_i | input | 1 | Watchdog-clear command strobe |
| sleep_i | input | 1 | Sleep command strobe |
| wdt_tmo_i | input | 1 | Watchdog timeout event strobe |
| sw_we_i | input | 1 | Software write strobe |
| sw_wdata_i | input | 8 | Software write data |
| stat_o | output | 8 | Registered status byte |

## Verification
Every result appears on `stat_o` exactly one rising edge after the strobe that causes it, because a single register lies between the inputs and the output. The bench drives each stimulus on a falling edge and removes it on the next falling edge. It compares the byte at that same falling edge, which is one full edge after the capture, against a model byte updated from the requirements. Priority cases put several strobes into the same cycle, so that one sample checks which source won for each bit.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_CMP  = 3'd2,
    OP_RLC  = 3'd3,
    OP_RRC  = 3'd4,
    OP_LOG  = 3'd5,
    OP_MOV  = 3'd6,
    OP_NONE = 3'd7
  } alu_op_e;

  localparam int unsigned NFLAG = 3;   // carry, digit carry, zero
  localparam int unsigned B_C   = 0;
  localparam int unsigned B_DC  = 1;
  localparam int unsigned B_Z   = 2;
  localparam int unsigned B_PD  = 3;
  localparam int unsigned B_TO  = 4;
  localparam int unsigned B_PG  = 5;   // lowest page bit
  localparam int unsigned NPAGE = 3;
endpackage

// File: rtl/sfu_flag_calc.sv
module sfu_flag_calc
  import sfu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  alu_op_e           op,
  input  logic [DW-1:0]     a,
  input  logic [DW-1:0]     b,
  input  logic [DW-1:0]     res,
  output logic [NFLAG-1:0]  nx,
  output logic [NFLAG-1:0]  upd
);
  localparam int unsigned NIB = DW / 2;

  logic [DW:0]  full_sum;
  logic [NIB:0] nib_sum;

  assign full_sum = {1'b0, a} + {1'b0, b};
  assign nib_sum  = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]};

  always_comb begin
    nx       = '0;
    upd      = '0;
    nx[B_Z]  = (res == '0);
    unique case (op)
      OP_ADD: begin
        nx[B_C]  = full_sum[DW];
        nx[B_DC] = nib_sum[NIB];
        upd      = '1;
      end
      OP_SUB, OP_CMP: begin
        nx[B_C]  = (a >= b);
        nx[B_DC] = (a[NIB-1:0] >= b[NIB-1:0]);
        upd      = '1;
      end
      OP_RLC: begin
        nx[B_C]  = a[DW-1];
        upd[B_C] = 1'b1;
      end
      OP_RRC: begin
        nx[B_C]  = a[0];
        upd[B_C] = 1'b1;
      end
      OP_LOG, OP_MOV: upd[B_Z] = 1'b1;
      OP_NONE: upd = '0;
      default: upd = '0;
    endcase
  end
endmodule

// File: rtl/sfu_pwr_flags.sv
module sfu_pwr_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic wdt_clr,
  input  logic sleep,
  input  logic wdt_tmo,
  output logic pd_q,
  output logic to_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q <= 1'b1;
      to_q <= 1'b1;
    end else begin
      if (wdt_clr)    pd_q <= 1'b1;
      else if (sleep) pd_q <= 1'b0;
      if (wdt_tmo)      to_q <= 1'b0;
      else if (wdt_clr) to_q <= 1'b1;
    end
  end

  p_wdt_sets_pd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr |=> pd_q);
  p_sleep_clears_pd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !wdt_clr) |=> !pd_q);
  p_tmo_clears_to_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_tmo |=> !to_q);
  p_clr_sets_to_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_clr && !wdt_tmo) |=> to_q);
endmodule

// File: rtl/stat_flag_unit.sv
module stat_flag_unit
  import sfu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    op_i,
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  input  logic [DW-1:0] res_i,
  input  logic          flag_we_i,
  input  logic          wdt_clr_i,
  input  logic          sleep_i,
  input  logic          wdt_tmo_i,
  input  logic          sw_we_i,
  input  logic [7:0]    sw_wdata_i,
  output logic [7:0]    stat_o
);
  localparam int unsigned NIB = DW / 2;

  alu_op_e             op;
  logic [NFLAG-1:0]    f_nx, f_upd, f_q;
  logic [NPAGE-1:0]    pg_q;
  logic                pd_q, to_q;

  assign op = alu_op_e'(op_i);

  sfu_flag_calc #(.DW(DW)) u_calc (
    .op  (op),
    .a   (opa_i),
    .b   (opb_i),
    .res (res_i),
    .nx  (f_nx),
    .upd (f_upd)
  );

  sfu_pwr_flags u_pwr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wdt_clr (wdt_clr_i),
    .sleep   (sleep_i),
    .wdt_tmo (wdt_tmo_i),
    .pd_q    (pd_q),
    .to_q    (to_q)
  );

  // Per-flag merge: ALU update beats software write, which beats hold.
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       f_q[i] <= 1'b0;
      else if (flag_we_i && f_upd[i])   f_q[i] <= f_nx[i];
      else if (sw_we_i)                 f_q[i] <= sw_wdata_i[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pg_q <= '0;
    else if (sw_we_i) pg_q <= sw_wdata_i[B_PG +: NPAGE];
  end

  assign stat_o = {pg_q, to_q, pd_q, f_q};

  p_add_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we_i && op == OP_ADD) |=>
      stat_o[B_C] == $past(({1'b0, opa_i} + {1'b0, opb_i}) >> DW));
  p_add_dcarry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we_i && op == OP_ADD) |=>
      stat_o[B_DC] == $past(({1'b0, opa_i[NIB-1:0]} + {1'b0, opb_i[NIB-1:0]}) >> NIB));
  p_sub_borrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we_i && (op == OP_SUB || op == OP_CMP)) |=>
      stat_o[B_C] == $past(opa_i >= opb_i));
  p_rot_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we_i && (op == OP_RLC || op == OP_RRC)) |=>
      stat_o[B_C] == $past(op == OP_RLC ? opa_i[DW-1] : opa_i[0]));
  p_rot_keeps_z_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we_i && !sw_we_i && (op == OP_RLC || op == OP_RRC)) |=>
      stat_o[B_Z] == $past(stat_o[B_Z]));
  p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we_i && op != OP_RLC && op != OP_RRC && op != OP_NONE) |=>
      stat_o[B_Z] == $past(res_i == '0));
  p_logic_keeps_c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we_i && !sw_we_i && (op == OP_LOG || op == OP_MOV)) |=>
      stat_o[1:0] == $past(stat_o[1:0]));
  p_ro_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we_i && !wdt_clr_i && !sleep_i && !wdt_tmo_i &&
     sw_wdata_i[4:3] != stat_o[4:3]) |=> stat_o[4:3] == $past(stat_o[4:3]));
  p_page_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we_i |=> stat_o[7:5] == $past(sw_wdata_i[7:5]));
  p_alu_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we_i && flag_we_i && op == OP_ADD) |=>
      stat_o[B_Z] == $past(res_i == '0));
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_we_i && !sw_we_i) |=>
      {stat_o[7:5], stat_o[2:0]} == $past({stat_o[7:5], stat_o[2:0]}));
endmodule

// File: tb/sim_stat_flag_unit.sv
module sim_stat_flag_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] op_i = 3'd7;
  logic [7:0] opa_i = '0, opb_i = '0, res_i = '0, sw_wdata_i = '0;
  logic       flag_we_i = 1'b0, wdt_clr_i = 1'b0, sleep_i = 1'b0;
  logic       wdt_tmo_i = 1'b0, sw_we_i = 1'b0;
  logic [7:0] stat_o;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_q;
  bit done = 0;

  always #4 clk = ~clk;

  stat_flag_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .opa_i(opa_i), .opb_i(opb_i),
    .res_i(res_i), .flag_we_i(flag_we_i), .wdt_clr_i(wdt_clr_i),
    .sleep_i(sleep_i), .wdt_tmo_i(wdt_tmo_i), .sw_we_i(sw_we_i),
    .sw_wdata_i(sw_wdata_i), .stat_o(stat_o)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: stat=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // One cycle of stimulus; model byte updated from the requirements.
  task automatic step(string tag, logic [2:0] op, logic [7:0] a, logic [7:0] b,
                      logic [7:0] r, logic fwe, logic swe, logic [7:0] wd,
                      logic wclr, logic slp, logic tmo);
    logic [7:0] n;
    @(negedge clk);
    op_i = op; opa_i = a; opb_i = b; res_i = r; flag_we_i = fwe;
    sw_we_i = swe; sw_wdata_i = wd; wdt_clr_i = wclr; sleep_i = slp; wdt_tmo_i = tmo;
    n = exp_q;
    if (swe) begin
      n[7:5] = wd[7:5];
      n[2:0] = wd[2:0];
    end
    if (fwe) begin
      case (op)
        3'd0: begin n[0] = ((a + 9'd0 + b) > 9'd255); n[1] = ((a[3:0] + 5'd0 + b[3:0]) > 5'd15); n[2] = (r == 0); end
        3'd1, 3'd2: begin n[0] = (a >= b); n[1] = (a[3:0] >= b[3:0]); n[2] = (r == 0); end
        3'd3: n[0] = a[7];
        3'd4: n[0] = a[0];
        3'd5, 3'd6: n[2] = (r == 0);
        default: ;
      endcase
    end
    if (wclr) n[3] = 1'b1; else if (slp) n[3] = 1'b0;
    if (tmo) n[4] = 1'b0; else if (wclr) n[4] = 1'b1;
    exp_q = n;
    @(negedge clk);
    flag_we_i = 0; sw_we_i = 0; wdt_clr_i = 0; sleep_i = 0; wdt_tmo_i = 0; op_i = 3'd7;
    check(tag, stat_o, exp_q);
  endtask

  task automatic t_reset;
    exp_q = 8'h18;
    check("R1 reset", stat_o, exp_q);
  endtask

  task automatic t_add;
    step("R2 add ff+01", 0, 8'hFF, 8'h01, 8'h00, 1, 0, 0, 0, 0, 0);
    step("R2 add 12+34", 0, 8'h12, 8'h34, 8'h46, 1, 0, 0, 0, 0, 0);
    step("R2 add 08+08", 0, 8'h08, 8'h08, 8'h10, 1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_sub;
    step("R3 sub 05-03", 1, 8'h05, 8'h03, 8'h02, 1, 0, 0, 0, 0, 0);
    step("R3 sub 03-05", 1, 8'h03, 8'h05, 8'hFE, 1, 0, 0, 0, 0, 0);
    step("R3 cmp 40=40", 2, 8'h40, 8'h40, 8'h00, 1, 0, 0, 0, 0, 0);
    step("R3 sub 20-11", 1, 8'h20, 8'h11, 8'h0F, 1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_rot;
    step("R4 rlc 80", 3, 8'h80, 8'h00, 8'h00, 1, 0, 0, 0, 0, 0);
    step("R4 rlc 7e", 3, 8'h7E, 8'h00, 8'h00, 1, 0, 0, 0, 0, 0);
    step("R4 rrc 01", 4, 8'h01, 8'h00, 8'h00, 1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_logic;
    step("R5 logic zero", 5, 8'h00, 8'h00, 8'h00, 1, 0, 0, 0, 0, 0);
    step("R6 move nonzero", 6, 8'h00, 8'h00, 8'h5A, 1, 0, 0, 0, 0, 0);
    step("R6 op7 none", 7, 8'hFF, 8'hFF, 8'h00, 1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_idle;
    step("R11 strobe low", 0, 8'hFF, 8'hFF, 8'h00, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_pwr;
    step("R7 sleep", 7, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    step("R7 wdt clear", 7, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    step("R8 timeout", 7, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step("R8 clear sets to", 7, 0, 0, 0, 0, 0, 0, 1, 1, 0);
  endtask

  task automatic t_sw;
    step("R9 write ff", 7, 0, 0, 0, 0, 1, 8'hFF, 0, 0, 0);
    step("R9 write 00", 7, 0, 0, 0, 0, 1, 8'h00, 0, 0, 0);
    step("R9 write a5", 7, 0, 0, 0, 0, 1, 8'hA5, 0, 0, 0);
  endtask

  task automatic t_prio;
    step("R10 add vs write", 0, 8'h12, 8'h34, 8'h46, 1, 1, 8'hE7, 0, 0, 0);
    step("R10 rot vs write", 3, 8'h00, 8'h00, 8'h00, 1, 1, 8'h07, 0, 0, 0);
    step("R10 logic vs write", 5, 8'h00, 8'h00, 8'h00, 1, 1, 8'h40, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_add();
    t_sub();
    t_rot();
    t_logic();
    t_idle();
    t_pwr();
    t_sw();
    t_prio();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(8 * 20000);
        checks++;
        fails++;
        $display("FAIL watchdog: stat=%02h expected=done", stat_o);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule